// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block produces a bit-serial keystream from three linear feedback shift registers whose stepping is irregular. A run begins with a start pulse. The 64-bit session key and the 22-bit frame number are captured on that pulse. The block then works through a fixed sequence. First it loads the key with all three registers stepping on every cycle. Next it loads the frame number the same way. It then runs 100 silent mixing steps under majority clocking. Finally it delivers 228 keystream bits, one per cycle, each marked by a valid strobe.

Majority clocking works as follows. One clock-control tap is taken from each register, and the majority of the three tap values is formed. Only the registers whose tap equals that majority advance in that cycle. Each keystream bit is the XOR of the three registers' most significant bits. A one-cycle done flag follows the last bit. The block does not combine the keystream with payload data and does not count frames. Any surrounding logic that needs a new frame issues a new start with a new frame number.

Top module: `maj_lfsr_keygen`

## Requirements
- R1: After reset, ks_valid_o, ks_bit_o and done_o are 0 and the block waits idle. A start_i that is high at a rising edge while idle begins a run and captures key_i and frame_i at that edge. Later changes on those inputs do not affect the run.
- R2: The three registers are 19, 22 and 23 bits long, with feedback polynomials x^19+x^5+x^2+x+1, x^22+x+1 and x^23+x^15+x^2+x+1. In shift form, bit 0 takes the new bit, the MSB is the oldest, and the feedback is the XOR of bits {18,17,16,13}, {21,20} and {22,21,20,7} respectively.
- R3: The start edge clears all registers to zero. On each of the next 64 edges, every register shifts up by one. Its bit 0 becomes the feedback XOR the next key bit, taken from key_i[0] upward.
- R4: The following 22 edges load frame_i the same way, from bit 0 upward, with all registers stepping regardless of the taps.
- R5: During mixing and output, the clock-control taps are bit 8, bit 10 and bit 10 of the 19-, 22- and 23-bit registers. The majority m is 1 when two or more taps are 1. A register steps (with a zero input bit) only when its tap equals m, and otherwise holds.
- R6: The next 100 edges are majority-clocked and produce no valid output.
- R7: The next 228 edges are majority-clocked. After each of them, ks_valid_o is 1 for one cycle, with ks_bit_o equal to the XOR of the three MSBs of the just-stepped state. Counting the start edge as edge 0, valid is high in the cycles following edges 187 through 414 and at no other time. ks_bit_o is 0 when not valid.
- R8: done_o is 1 for exactly the one cycle following edge 415, right after the last valid cycle. The block is then idle again.
- R9: A start_i pulse while a run is in progress is ignored. The run's timing and bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a run when seen high while idle |
| key_i | input | 64 | Session key, captured at the start edge |
| frame_i | input | 22 | Frame number, captured at the start edge |
| ks_bit_o | output | 1 | Keystream bit, meaningful when valid |
| ks_valid_o | output | 1 | Marks each of the 228 keystream bits |
| done_o | output | 1 | One-cycle pulse after the last keystream bit |

## Verification
The start edge is counted as edge 0. The run then takes 64 key edges, 22 frame edges and 100 mixing edges. The first keystream bit is therefore visible in the cycle after edge 187, the last in the cycle after edge 414, and done_o in the cycle after edge 415. The bench computes the expected bit sequence with a behavioural model ahead of each run. It then compares valid, bit and done at every falling edge from edge 0 to edge 420 against that schedule, so every result is checked in the cycle it is due and nowhere else. Stray start pulses are injected during the load and output phases, and the inputs are scrambled after capture, to show that neither disturbs the schedule.

// File: rtl/mkg_pkg.sv
package mkg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_KEY   = 3'd1,
    PH_FRAME = 3'd2,
    PH_MIX   = 3'd3,
    PH_GEN   = 3'd4
  } phase_t;

  // Majority of three tap bits.
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Parity of the bits of a state selected by a tap mask.
  function automatic logic masked_parity(input logic [31:0] st, input logic [31:0] mask);
    return ^(st & mask);
  endfunction

endpackage

// File: rtl/mkg_lfsr.sv
module mkg_lfsr #(
  parameter int          LEN      = 19,
  parameter logic [31:0] TAP_MASK = 32'h0007_2000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           step_i,
  input  logic           in_i,
  output logic [LEN-1:0] state_o
);
  import mkg_pkg::*;

  logic [31:0] st_ext;
  logic        fb;

  assign st_ext = 32'(state_o);
  assign fb     = masked_parity(st_ext, TAP_MASK) ^ in_i;

  always_ff @(posedge clk) begin
    if (!rst_n)       state_o <= '0;
    else if (clear_i) state_o <= '0;
    else if (step_i)  state_o <= {state_o[LEN-2:0], fb};
  end
endmodule

// File: rtl/mkg_seq.sv
module mkg_seq #(
  parameter int KEY_W   = 64,
  parameter int FRAME_W = 22,
  parameter int MIX_CYC = 100,
  parameter int OUT_CYC = 228,
  parameter int CNT_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  output mkg_pkg::phase_t      phase_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 launch_o,
  output logic                 last_o
);
  import mkg_pkg::*;

  logic key_end, frame_end, mix_end;

  assign launch_o  = (phase_o == PH_IDLE) && start_i;
  assign key_end   = (phase_o == PH_KEY)   && (cnt_o == CNT_W'(KEY_W - 1));
  assign frame_end = (phase_o == PH_FRAME) && (cnt_o == CNT_W'(FRAME_W - 1));
  assign mix_end   = (phase_o == PH_MIX)   && (cnt_o == CNT_W'(MIX_CYC - 1));
  assign last_o    = (phase_o == PH_GEN)   && (cnt_o == CNT_W'(OUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_o <= PH_IDLE;
      cnt_o   <= '0;
    end else begin
      unique case (phase_o)
        PH_IDLE: begin
          if (start_i) begin
            phase_o <= PH_KEY;
            cnt_o   <= '0;
          end
        end
        PH_KEY: begin
          if (key_end) begin phase_o <= PH_FRAME; cnt_o <= '0; end
          else cnt_o <= cnt_o + 1'b1;
        end
        PH_FRAME: begin
          if (frame_end) begin phase_o <= PH_MIX; cnt_o <= '0; end
          else cnt_o <= cnt_o + 1'b1;
        end
        PH_MIX: begin
          if (mix_end) begin phase_o <= PH_GEN; cnt_o <= '0; end
          else cnt_o <= cnt_o + 1'b1;
        end
        PH_GEN: begin
          if (last_o) begin phase_o <= PH_IDLE; cnt_o <= '0; end
          else cnt_o <= cnt_o + 1'b1;
        end
        default: begin
          phase_o <= PH_IDLE;
          cnt_o   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/maj_lfsr_keygen.sv
module maj_lfsr_keygen #(
  parameter int          KEY_W   = 64,
  parameter int          FRAME_W = 22,
  parameter int          MIX_CYC = 100,
  parameter int          OUT_CYC = 228,
  parameter int          LEN_A   = 19,
  parameter int          LEN_B   = 22,
  parameter int          LEN_C   = 23,
  parameter logic [31:0] MASK_A  = 32'h0007_2000,
  parameter logic [31:0] MASK_B  = 32'h0030_0000,
  parameter logic [31:0] MASK_C  = 32'h0070_0080,
  parameter int          CTAP_A  = 8,
  parameter int          CTAP_B  = 10,
  parameter int          CTAP_C  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [KEY_W-1:0]   key_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ks_bit_o,
  output logic               ks_valid_o,
  output logic               done_o
);
  import mkg_pkg::*;

  localparam int MAX_AB = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int MAXL   = (MAX_AB > LEN_C) ? MAX_AB : LEN_C;
  localparam int MAX_KF = (KEY_W > FRAME_W) ? KEY_W : FRAME_W;
  localparam int MAX_MO = (MIX_CYC > OUT_CYC) ? MIX_CYC : OUT_CYC;
  localparam int MAXC   = (MAX_KF > MAX_MO) ? MAX_KF : MAX_MO;
  localparam int CNT_W  = $clog2(MAXC + 1);

  // Named internal events for the checker.
  phase_t                phase_w;
  logic [CNT_W-1:0]      cnt_w;
  logic                  launch_w;
  logic                  last_w;
  logic                  load_ph_w;
  logic                  maj_ph_w;
  logic                  maj_w;
  logic                  in_bit_w;
  logic [2:0]            tap_vec_w;
  logic [2:0]            msb_vec_w;
  logic [2:0]            step_vec_w;
  logic [2:0][MAXL-1:0]  lane_st_w;

  logic [KEY_W-1:0]      key_sh_q;
  logic [FRAME_W-1:0]    frame_sh_q;
  logic                  valid_q;
  logic                  last_q;
  logic                  done_q;

  mkg_seq #(
    .KEY_W  (KEY_W),
    .FRAME_W(FRAME_W),
    .MIX_CYC(MIX_CYC),
    .OUT_CYC(OUT_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .phase_o (phase_w),
    .cnt_o   (cnt_w),
    .launch_o(launch_w),
    .last_o  (last_w)
  );

  // Captured key and frame number, consumed LSB first.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_sh_q   <= '0;
      frame_sh_q <= '0;
    end else if (launch_w) begin
      key_sh_q   <= key_i;
      frame_sh_q <= frame_i;
    end else begin
      if (phase_w == PH_KEY)   key_sh_q   <= key_sh_q >> 1;
      if (phase_w == PH_FRAME) frame_sh_q <= frame_sh_q >> 1;
    end
  end

  assign load_ph_w = (phase_w == PH_KEY) || (phase_w == PH_FRAME);
  assign maj_ph_w  = (phase_w == PH_MIX) || (phase_w == PH_GEN);
  assign in_bit_w  = (phase_w == PH_KEY)   ? key_sh_q[0]   :
                     (phase_w == PH_FRAME) ? frame_sh_q[0] : 1'b0;
  assign maj_w     = maj3(tap_vec_w[0], tap_vec_w[1], tap_vec_w[2]);

  for (genvar g = 0; g < 3; g++) begin : g_lane
    localparam int          L = (g == 0) ? LEN_A  : (g == 1) ? LEN_B  : LEN_C;
    localparam logic [31:0] M = (g == 0) ? MASK_A : (g == 1) ? MASK_B : MASK_C;
    localparam int          C = (g == 0) ? CTAP_A : (g == 1) ? CTAP_B : CTAP_C;

    logic [L-1:0] st;

    assign step_vec_w[g] = load_ph_w || (maj_ph_w && (tap_vec_w[g] == maj_w));

    mkg_lfsr #(
      .LEN     (L),
      .TAP_MASK(M)
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i(launch_w),
      .step_i (step_vec_w[g]),
      .in_i   (in_bit_w),
      .state_o(st)
    );

    assign lane_st_w[g] = MAXL'(st);
    assign tap_vec_w[g] = st[C];
    assign msb_vec_w[g] = st[L-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= (phase_w == PH_GEN);
      last_q  <= last_w;
      done_q  <= last_q;
    end
  end

  assign ks_valid_o = valid_q;
  assign ks_bit_o   = valid_q & (^msb_vec_w);
  assign done_o     = done_q;

endmodule

// File: rtl/mkg_checker.sv
module mkg_checker #(
  parameter int MAXL  = 23,
  parameter int LEN_A = 19,
  parameter int CNT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 ks_valid_o,
  input logic                 done_o,
  input mkg_pkg::phase_t      phase_w,
  input logic [CNT_W-1:0]     cnt_w,
  input logic                 maj_ph_w,
  input logic                 maj_w,
  input logic [2:0]           tap_vec_w,
  input logic [2:0][MAXL-1:0] lane_st_w
);
  import mkg_pkg::*;

  // R3: key loading shifts the first register every cycle.
  assert_keyload_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_w == PH_KEY) |=> (lane_st_w[0][LEN_A-1:1] == $past(lane_st_w[0][LEN_A-2:0])));

  // R5: a register whose tap disagrees with the majority holds.
  assert_hold_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (maj_ph_w && (tap_vec_w[0] != maj_w)) |=> $stable(lane_st_w[0]));
  assert_hold_lane2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (maj_ph_w && (tap_vec_w[2] != maj_w)) |=> $stable(lane_st_w[2]));

  // R6: no valid output follows a mixing step.
  assert_quiet_mix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_w == PH_MIX) |=> !ks_valid_o);

  // R7: valid only follows an output-phase step.
  assert_valid_gen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid_o |-> ($past(phase_w) == PH_GEN));

  // R8: done is a single pulse right after the last valid cycle.
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_after_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(ks_valid_o) && !ks_valid_o));

  // R9: a start seen mid-run never restarts the key phase.
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_w != PH_IDLE) && start_i) |=> !((phase_w == PH_KEY) && (cnt_w == '0)));

endmodule

bind maj_lfsr_keygen mkg_checker #(
  .MAXL (MAXL),
  .LEN_A(LEN_A),
  .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .ks_valid_o(ks_valid_o),
  .done_o    (done_o),
  .phase_w   (phase_w),
  .cnt_w     (cnt_w),
  .maj_ph_w  (maj_ph_w),
  .maj_w     (maj_w),
  .tap_vec_w (tap_vec_w),
  .lane_st_w (lane_st_w)
);

// File: tb/maj_lfsr_keygen_tb.sv
module maj_lfsr_keygen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] key_i = '0;
  logic [21:0] frame_i = '0;
  logic        ks_bit_o, ks_valid_o, done_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  maj_lfsr_keygen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .key_i     (key_i),
    .frame_i   (frame_i),
    .ks_bit_o  (ks_bit_o),
    .ks_valid_o(ks_valid_o),
    .done_o    (done_o)
  );

  // Behavioural reference: three bit arrays stepped one bit at a time.
  bit rg[3][23];
  int ln[3] = '{19, 22, 23};
  int ct[3] = '{8, 10, 10};
  bit exp_q[$];

  function automatic bit feedback(int i);
    case (i)
      0:       return rg[0][18] ^ rg[0][17] ^ rg[0][16] ^ rg[0][13];
      1:       return rg[1][21] ^ rg[1][20];
      default: return rg[2][22] ^ rg[2][21] ^ rg[2][20] ^ rg[2][7];
    endcase
  endfunction

  task automatic advance(int i, bit inb);
    bit nb;
    nb = feedback(i) ^ inb;
    for (int b = ln[i] - 1; b > 0; b--) rg[i][b] = rg[i][b-1];
    rg[i][0] = nb;
  endtask

  task automatic irregular_step();
    int ones;
    bit m;
    ones = 0;
    for (int i = 0; i < 3; i++) ones += int'(rg[i][ct[i]]);
    m = (ones >= 2);
    for (int i = 0; i < 3; i++) if (rg[i][ct[i]] == m) advance(i, 1'b0);
  endtask

  task automatic build_model(logic [63:0] k, logic [21:0] f);
    exp_q.delete();
    for (int i = 0; i < 3; i++) for (int b = 0; b < 23; b++) rg[i][b] = 1'b0;
    for (int t = 0; t < 64; t++) for (int i = 0; i < 3; i++) advance(i, k[t]);
    for (int t = 0; t < 22; t++) for (int i = 0; i < 3; i++) advance(i, f[t]);
    for (int t = 0; t < 100; t++) irregular_step();
    for (int t = 0; t < 228; t++) begin
      irregular_step();
      exp_q.push_back(rg[0][18] ^ rg[1][21] ^ rg[2][22]);
    end
  endtask

  task automatic check(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: cycle %0d actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  // One full run compared on every clock from edge 0 through edge 420.
  task automatic run(logic [63:0] k, logic [21:0] f, bit poke);
    bit ev, ed, eb;
    build_model(k, f);
    @(negedge clk);
    key_i   = k;
    frame_i = f;
    start_i = 1'b1;
    @(posedge clk);  // edge 0
    for (int e = 0; e <= 420; e++) begin
      if (e > 0) @(posedge clk);
      @(negedge clk);
      if (e == 0) begin
        start_i = 1'b0;
        key_i   = ~k;   // R1: later input changes must not matter
        frame_i = ~f;
      end
      if (poke) start_i = (e == 30 || e == 250 || e == 100);  // R9
      else      start_i = 1'b0;
      ev = (e >= 187) && (e <= 414);
      ed = (e == 415);
      eb = ev ? exp_q[e - 187] : 1'b0;
      check(ks_valid_o == ev, "R6 R7 valid", int'(ks_valid_o), int'(ev));
      check(done_o == ed, "R8 done", int'(done_o), int'(ed));
      // R2 R3 R4 R5 R7: bit value from the reference model
      check(ks_bit_o == eb, poke ? "R9 R7 bit" : "R2 R3 R4 R5 R7 bit",
            int'(ks_bit_o), int'(eb));
    end
    start_i = 1'b0;
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    tests++;
    $display("FAIL watchdog: cycle %0d actual hung expected finish", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(ks_valid_o == 1'b0, "R1 valid", int'(ks_valid_o), 0);
    check(done_o == 1'b0, "R1 done", int'(done_o), 0);
    check(ks_bit_o == 1'b0, "R1 bit", int'(ks_bit_o), 0);
    // R1: idle with no start stays quiet
    repeat (10) @(negedge clk);
    check(ks_valid_o == 1'b0, "R1 idle", int'(ks_valid_o), 0);

    run(64'h0, 22'h0, 1'b0);                       // R3: all-zero input
    run(64'h0123_4567_89AB_CDEF, 22'h13_4567, 1'b0);
    run(64'h8000_0000_0000_0001, 22'h20_0001, 1'b0); // R3 R4: end bits
    run(64'hFFFF_FFFF_FFFF_FFFF, 22'h3F_FFFF, 1'b0);
    run(64'h5A5A_C3C3_0F0F_9696, 22'h15_2A3C, 1'b1); // R9: stray starts

    // R8: idle again afterwards
    repeat (5) @(negedge clk);
    check(ks_valid_o == 1'b0 && done_o == 1'b0, "R8 idle after",
          int'({ks_valid_o, done_o}), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule